// File: doc/BRIEF.md
# I2C Register-Read Sequencer

This block drives the byte-level register interface of an I2C master engine so that a single byte can be fetched from a register inside an addressed I2C device. The block is given a 7-bit device address and an 8-bit register index. It then works through a fixed four-step program on the engine:

1. A dummy write of the device address.
2. The register index.
3. A repeated start carrying the device address with the read bit set.
4. A single-byte read that ends with a master NACK and a STOP.

Every step goes through the engine's transmit, command, status and receive registers. A simple request/acknowledge bus carries these accesses.

After each command the block polls the engine's status register. It moves on only when the transfer-in-progress flag has dropped. For the three write steps it also needs an ACK from the slave. A slave NACK makes the block issue a STOP and report an error. An engine that stays busy for too many polls also makes the block issue a STOP and report an error.

The result leaves the block as a byte plus an error flag, qualified by a single-cycle done pulse. The result port has no back-pressure: the consumer must take the byte in the cycle that done is high. The request side is a start pulse. It is taken only while the block is idle, and the block does not queue it.

Top module: `i2c_rdseq`

## Requirements
- R1: A start pulse while `busy` is low latches `dev_addr` and `reg_addr`, and `busy` is high in the following cycle. A start pulse while `busy` is high has no effect on the running transaction, and no second transaction follows it.
- R2: The first two writes are as follows. The transmit register (bus address 3) receives `{dev_addr, 0}`. The command register (bus address 4) then receives 0x90, which is START (bit 7) plus WRITE (bit 4).
- R3: After every command write, the block reads the status register (bus address 4) until bit 1 (transfer in progress) reads 0. For the first three commands it continues only if bit 7 (received NACK) is also 0.
- R4: The second step writes the register index to the transmit register, then writes 0x10 (WRITE only) to the command register.
- R5: The third step writes `{dev_addr, 1}` to the transmit register, then writes 0x90 to the command register, which forms a repeated start.
- R6: The fourth step writes 0x68 to the command register. This is READ (bit 5), NACK-on-receive (bit 3) and STOP (bit 6). The step waits only for bit 1 to clear, so status bit 7 is ignored. The block then reads the receive register (bus address 3) and returns that byte with `err` at 0.
- R7: A bus access holds `bus_req` high with stable `bus_we`, `bus_addr` and `bus_wdata` until `bus_ack` is seen. `bus_req` is low in the cycle after the acknowledge, so only one access is ever outstanding.
- R8: A NACK seen after any of the first three commands causes a write of 0x40 (STOP) to the command register. The block then completes with `err` at 1 and `rd_data` at 0.
- R9: POLL_MAX consecutive status reads with bit 1 set cause the STOP write and an error completion. POLL_MAX−1 busy reads followed by a clear read do not.
- R10: `done` is high for exactly one cycle per transaction, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| dev_addr | input | 7 | I2C device address |
| reg_addr | input | 8 | Register index inside the device |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion ended in NACK or timeout |
| rd_data | output | 8 | Byte read, valid with done |
| bus_req | output | 1 | Engine register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W (3) | Engine register index |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
The bench builds the block with POLL_MAX set to 5, so an engine that never clears its busy flag trips the timeout after five status reads. A run with four busy reads followed by a clear one sits exactly at the boundary where the block must still succeed. The default register indices are kept. The responder's acknowledge latency varies from 0 to 2 cycles across transactions, which tests the request-hold rule under both back-to-back and stretched acknowledges. Scripted NACKs on each of the four commands cover every abort point and the ignored NACK on the read step.

// File: rtl/rdseq_pkg.sv
`timescale 1ns/1ps
package rdseq_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  // command register bits decoded by the engine
  localparam int CB_START = 7;
  localparam int CB_STOP  = 6;
  localparam int CB_READ  = 5;
  localparam int CB_WRITE = 4;
  localparam int CB_NACK  = 3;
  // status register bits driven by the engine
  localparam int SB_RXNACK = 7;
  localparam int SB_BUSY   = 1;

  localparam logic [BYTE_W-1:0] CMD_STOP_ONLY = BYTE_W'(1 << CB_STOP);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TXW, ST_CMDW, ST_POLL, ST_RXR, ST_STOPW, ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {SEL_TX, SEL_CMD, SEL_STAT, SEL_RX} reg_sel_e;

  typedef struct packed {
    logic              we;
    reg_sel_e          sel;
    logic [BYTE_W-1:0] wdata;
  } acc_t;

  // command byte for each of the four program steps
  function automatic logic [BYTE_W-1:0] cmd_for_step(input logic [1:0] step);
    case (step)
      2'd1:    return BYTE_W'(1 << CB_WRITE);
      2'd3:    return BYTE_W'((1 << CB_READ) | (1 << CB_NACK) | (1 << CB_STOP));
      default: return BYTE_W'((1 << CB_START) | (1 << CB_WRITE));
    endcase
  endfunction

  // transmit byte for the three write steps
  function automatic logic [BYTE_W-1:0] tx_for_step(input logic [1:0] step,
                                                    input logic [DEV_W-1:0] dev,
                                                    input logic [BYTE_W-1:0] rg);
    case (step)
      2'd0:    return {dev, 1'b0};
      2'd1:    return rg;
      default: return {dev, 1'b1};
    endcase
  endfunction
endpackage

// File: rtl/rdseq_bus_port.sv
`timescale 1ns/1ps
module rdseq_bus_port
  import rdseq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int ADDR_TX   = 3,
  parameter int ADDR_CMD  = 4,
  parameter int ADDR_STAT = 4,
  parameter int ADDR_RX   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  acc_t              acc,
  output logic              free,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  logic [ADDR_W-1:0] sel_addr;

  always_comb begin
    case (acc.sel)
      SEL_TX:   sel_addr = ADDR_W'(ADDR_TX);
      SEL_CMD:  sel_addr = ADDR_W'(ADDR_CMD);
      SEL_STAT: sel_addr = ADDR_W'(ADDR_STAT);
      default:  sel_addr = ADDR_W'(ADDR_RX);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (bus_req && bus_ack) begin
      bus_req <= 1'b0;
    end else if (go && !bus_req) begin
      bus_req   <= 1'b1;
      bus_we    <= acc.we;
      bus_addr  <= sel_addr;
      bus_wdata <= acc.wdata;
    end
  end

  assign free  = !bus_req;
  assign done  = bus_req && bus_ack;
  assign rdata = bus_rdata;

  // R7: request and its fields held until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  // R7: request released after acknowledge
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);
endmodule

// File: rtl/rdseq_poll_timer.sv
`timescale 1ns/1ps
module rdseq_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  assign expired = hit && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (hit && !expired) cnt <= cnt + 1'b1;
  end

  // R9: count of busy polls never reaches the limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(LIMIT));
endmodule

// File: rtl/rdseq_step_ctl.sv
`timescale 1ns/1ps
module rdseq_step_ctl
  import rdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DEV_W-1:0]  dev_in,
  input  logic [BYTE_W-1:0] reg_in,
  output logic              acc_go,
  output acc_t              acc,
  input  logic              acc_free,
  input  logic              acc_done,
  input  logic [BYTE_W-1:0] acc_rdata,
  output logic              tmr_clr,
  output logic              tmr_hit,
  input  logic              tmr_expired,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [BYTE_W-1:0] rd_data
);
  seq_state_e        state;
  logic [1:0]        step;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] reg_q;
  logic              st_busy, st_nack, active;

  assign st_busy = acc_rdata[SB_BUSY];
  assign st_nack = acc_rdata[SB_RXNACK];
  assign active  = (state != ST_IDLE) && (state != ST_FIN);
  assign acc_go  = active && acc_free;
  assign tmr_clr = (state == ST_CMDW) && acc_done;
  assign tmr_hit = (state == ST_POLL) && acc_done && st_busy;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);

  always_comb begin
    acc = '{we: 1'b1, sel: SEL_CMD, wdata: cmd_for_step(step)};
    case (state)
      ST_TXW:   acc = '{we: 1'b1, sel: SEL_TX,   wdata: tx_for_step(step, dev_q, reg_q)};
      ST_POLL:  acc = '{we: 1'b0, sel: SEL_STAT, wdata: '0};
      ST_RXR:   acc = '{we: 1'b0, sel: SEL_RX,   wdata: '0};
      ST_STOPW: acc = '{we: 1'b1, sel: SEL_CMD,  wdata: CMD_STOP_ONLY};
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= 2'd0;
      dev_q   <= '0;
      reg_q   <= '0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          dev_q <= dev_in;
          reg_q <= reg_in;
          step  <= 2'd0;
          state <= ST_TXW;
        end
        ST_TXW:  if (acc_done) state <= ST_CMDW;
        ST_CMDW: if (acc_done) state <= ST_POLL;
        ST_POLL: if (acc_done) begin
          if (st_busy) begin
            if (tmr_expired) state <= ST_STOPW;
          end else if (step != 2'd3 && st_nack) begin
            state <= ST_STOPW;
          end else if (step == 2'd3) begin
            state <= ST_RXR;
          end else if (step == 2'd2) begin
            step  <= 2'd3;
            state <= ST_CMDW;
          end else begin
            step  <= step + 2'd1;
            state <= ST_TXW;
          end
        end
        ST_RXR: if (acc_done) begin
          rd_data <= acc_rdata;
          err     <= 1'b0;
          state   <= ST_FIN;
        end
        ST_STOPW: if (acc_done) begin
          rd_data <= '0;
          err     <= 1'b1;
          state   <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: accepted request makes the block busy
  p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: idle right after done
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R8: error completion carries a zero byte
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rd_data == '0));
endmodule

// File: rtl/i2c_rdseq.sv
`timescale 1ns/1ps
module i2c_rdseq
  import rdseq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int ADDR_TX   = 3,
  parameter int ADDR_CMD  = 4,
  parameter int ADDR_STAT = 4,
  parameter int ADDR_RX   = 3,
  parameter int POLL_MAX  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [6:0]        dev_addr,
  input  logic [7:0]        reg_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [7:0]        rd_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ack
);
  acc_t              acc;
  logic              acc_go, acc_free, acc_done;
  logic [BYTE_W-1:0] acc_rdata;
  logic              tmr_clr, tmr_hit, tmr_expired;

  rdseq_step_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_in(dev_addr), .reg_in(reg_addr),
    .acc_go(acc_go), .acc(acc), .acc_free(acc_free), .acc_done(acc_done),
    .acc_rdata(acc_rdata), .tmr_clr(tmr_clr), .tmr_hit(tmr_hit),
    .tmr_expired(tmr_expired), .busy(busy), .done(done), .err(err), .rd_data(rd_data)
  );

  rdseq_bus_port #(
    .ADDR_W(ADDR_W), .ADDR_TX(ADDR_TX), .ADDR_CMD(ADDR_CMD),
    .ADDR_STAT(ADDR_STAT), .ADDR_RX(ADDR_RX)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .go(acc_go), .acc(acc), .free(acc_free),
    .done(acc_done), .rdata(acc_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  rdseq_poll_timer #(.LIMIT(POLL_MAX)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .hit(tmr_hit), .expired(tmr_expired)
  );
endmodule

// File: tb/sim_i2c_rdseq.sv
`timescale 1ns/1ps
module sim_i2c_rdseq;
  localparam int POLL_LIM = 5;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [7:0] reg_addr = '0;
  logic       busy, done, err;
  logic [7:0] rd_data;
  logic       bus_req, bus_we, bus_ack;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  i2c_rdseq #(.POLL_MAX(POLL_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr), .reg_addr(reg_addr),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  int checks = 0, fails = 0;
  bit all_done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- engine responder ----------------
  int   cfg_lat = 0, cfg_tip = 0, cfg_nack_at = 0, cfg_hang_at = 0, cfg_base = 0;
  logic [7:0] cfg_rx = '0;
  int   dly, cmd_cnt, stat_cnt, tip_left;
  logic nack_now, hang_now;

  assign bus_rdata = (bus_addr == 3'd4) ?
    {nack_now, 5'b0, (hang_now || tip_left != 0), 1'b0} : cfg_rx;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; dly <= 0; cmd_cnt <= 0; stat_cnt <= 0;
      tip_left <= 0; nack_now <= 1'b0; hang_now <= 1'b0;
    end else begin
      if (bus_ack) bus_ack <= 1'b0;
      else if (bus_req) begin
        if (dly >= cfg_lat) begin bus_ack <= 1'b1; dly <= 0; end
        else dly <= dly + 1;
      end
      if (bus_req && bus_ack && bus_addr == 3'd4) begin
        if (bus_we) begin
          cmd_cnt <= cmd_cnt + 1;
          if (bus_wdata == 8'h40) begin
            tip_left <= 0; nack_now <= 1'b0; hang_now <= 1'b0;
          end else begin
            tip_left <= cfg_tip;
            nack_now <= (cmd_cnt + 1 - cfg_base == cfg_nack_at);
            hang_now <= (cmd_cnt + 1 - cfg_base == cfg_hang_at);
          end
        end else begin
          stat_cnt <= stat_cnt + 1;
          if (tip_left > 0) tip_left <= tip_left - 1;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  int    exp_addr[$], exp_data[$];
  string exp_tag[$];
  int    res_data[$], res_err[$];
  string res_tag[$];
  int    done_cnt = 0;
  logic       p_req = 0, p_ack = 0, p_we = 0;
  logic [2:0] p_addr = '0;
  logic [7:0] p_wdata = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !p_ack)
        chk(bus_req && bus_addr == p_addr && bus_we == p_we && bus_wdata == p_wdata,
            "R7", "request held", {bus_req, bus_addr, bus_wdata}, {1'b1, p_addr, p_wdata});
      if (p_req && p_ack) chk(!bus_req, "R7", "request released", bus_req, 0);
      if (bus_req && bus_ack && bus_we) begin
        if (exp_addr.size() == 0) chk(0, "R1", "unexpected write", {bus_addr, bus_wdata}, 0);
        else begin
          automatic int ea = exp_addr.pop_front();
          automatic int ed = exp_data.pop_front();
          automatic string et = exp_tag.pop_front();
          chk(bus_addr == ea[2:0] && bus_wdata == ed[7:0], et, "write addr/data",
              {bus_addr, bus_wdata}, {ea[2:0], ed[7:0]});
        end
      end
      if (done) begin
        done_cnt++;
        if (res_data.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          automatic int xd = res_data.pop_front();
          automatic int xe = res_err.pop_front();
          automatic string xt = res_tag.pop_front();
          chk(rd_data == xd[7:0] && err == xe[0], xt, "result {err,data}",
              {err, rd_data}, {xe[0], xd[7:0]});
        end
      end
    end
    p_req = bus_req; p_ack = bus_ack; p_we = bus_we; p_addr = bus_addr; p_wdata = bus_wdata;
  end

  task automatic push_w(input int a, input int d, input string t);
    exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  // driver: one transaction; stop_at = command index at which the block must abort (0 = none)
  task automatic run(input logic [6:0] dev, input logic [7:0] rg, input logic [7:0] rx,
                     input int tip, input int nack_at, input int hang_at, input int lat,
                     input bit poke, input int exp_stat);
    int stop_at, s0, d0;
    string stag;
    stop_at = 0;
    stag = "R6";
    if (nack_at >= 1 && nack_at <= 3) begin stop_at = nack_at; stag = "R8"; end
    if (hang_at != 0 && (stop_at == 0 || hang_at < stop_at)) begin stop_at = hang_at; stag = "R9"; end
    cfg_lat = lat; cfg_tip = tip; cfg_nack_at = nack_at; cfg_hang_at = hang_at;
    cfg_rx = rx; cfg_base = cmd_cnt;
    for (int c = 1; c <= 4; c++) begin
      if (stop_at == 0 || c <= stop_at) begin
        case (c)
          1: begin push_w(3, {dev, 1'b0}, "R2"); push_w(4, 8'h90, "R2"); end
          2: begin push_w(3, rg, "R4"); push_w(4, 8'h10, "R4"); end
          3: begin push_w(3, {dev, 1'b1}, "R5"); push_w(4, 8'h90, "R5"); end
          default: push_w(4, 8'h68, "R6");
        endcase
      end
    end
    if (stop_at != 0) begin
      push_w(4, 8'h40, stag);
      res_data.push_back(0); res_err.push_back(1);
    end else begin
      res_data.push_back(rx); res_err.push_back(0);
    end
    res_tag.push_back(stag);
    s0 = stat_cnt; d0 = done_cnt;
    @(negedge clk);
    start = 1'b1; dev_addr = dev; reg_addr = rg;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; dev_addr = ~dev; reg_addr = ~rg;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "busy after done", busy, 0);
    if (exp_stat >= 0) chk(stat_cnt - s0 == exp_stat, stag == "R9" ? "R9" : "R3",
                           "status reads", stat_cnt - s0, exp_stat);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && exp_addr.size() == 0, "R1", "no further activity",
        {busy, 8'(exp_addr.size())}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "reset busy", busy, 0);
    chk(done == 0, "R10", "reset done", done, 0);
    chk(bus_req == 0, "R7", "reset bus_req", bus_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(7'h50, 8'h1A, 8'hC3, 1, 0, 0, 0, 0, 8);        // R2 R4 R5 R6 basic
    run(7'h23, 8'hFF, 8'h00, 3, 0, 0, 2, 1, 16);       // R1 ignored start
    run(7'h11, 8'h05, 8'h77, 0, 1, 0, 1, 0, 1);        // R8 address NACK
    run(7'h12, 8'h06, 8'h77, 2, 2, 0, 0, 0, -1);       // R8 register NACK
    run(7'h13, 8'h07, 8'h77, 0, 3, 0, 2, 0, -1);       // R8 repeated-start NACK
    run(7'h7F, 8'h80, 8'hA5, 0, 4, 0, 1, 0, 4);        // R6 NACK on read ignored
    run(7'h00, 8'h00, 8'h5A, POLL_LIM - 1, 0, 0, 0, 0, 4 * POLL_LIM); // R9 boundary
    run(7'h2A, 8'h33, 8'h99, 0, 0, 1, 0, 0, POLL_LIM); // R9 timeout first command
    run(7'h2B, 8'h34, 8'h99, 1, 0, 4, 1, 0, 6 + POLL_LIM); // R9 timeout read step
    run(7'h01, 8'hFE, 8'h3C, 0, 0, 0, 0, 0, 4);        // recovery after abort
    all_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!all_done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule